// File: doc/BRIEF.md
# Pipelined Fully Connected Layer Engine

The block evaluates one dense perceptron layer with a single multiply-accumulate datapath that takes a new operand pair on every clock. A pulse on `start` begins a pass. The sequencer then walks an outer loop over neurons and an inner loop over inputs, and it issues one read address per cycle to three external synchronous memories: the weight array, the bias array and the upstream activation buffer. Each memory returns its data one cycle after the address. For each neuron the accumulator is seeded with that neuron's bias on the first input, so the bias costs no extra cycle. After the last input the sum goes through a ReLU and is rescaled and saturated back to the activation width. The result then leaves the block as a one-cycle `y_valid` write carrying the neuron index.

Arithmetic is signed fixed point. Activations and weights are `DW` bits wide with `FRAC` fractional bits. Biases use the activation format, and the accumulator is `ACC_W` bits wide. A pass occupies the issue slot for exactly N_IN × N_OUT cycles. A new start is accepted in the final issue cycle, so consecutive passes run with no gap. The `y_valid` stream can feed the input buffer of a following layer, which lets cascaded layers run at the same time.

Top module: `fcl_engine`

## Requirements
- R1: For each neuron n, y_data = min(floor(S / 2^FRAC), 2^(DW-1)-1), where S = b[n]·2^FRAC + Σ_i w[n·N_IN+i]·x[i] and S ≥ 0. All operands are two's complement.
- R2: When S is negative, y_data is 0.
- R3: When floor(S / 2^FRAC) exceeds 2^(DW-1)-1, y_data is exactly 2^(DW-1)-1.
- R4: Cycle c of a pass starts at the accepting clock edge, with c = 0 right after it. For c below N_IN·N_OUT the block presents w_addr = c, x_addr = c mod N_IN and b_addr = c div N_IN, with no idle cycle. Read data is sampled one clock after its address.
- R5: Each pass produces exactly N_OUT one-cycle y_valid pulses in ascending y_idx order. Neuron n appears (n+1)·N_IN+3 cycles after the accepting edge.
- R6: done is a one-cycle pulse N_IN·N_OUT+4 cycles after the accepting edge, one cycle after the final neuron's y_valid. busy is high from the accepting edge until the final issue cycle, where it is low.
- R7: start is ignored while busy is high. The pass's addresses, outputs and timing are unchanged.
- R8: start in the final issue cycle begins the next pass on the following cycle. Results repeat with a period of N_IN·N_OUT cycles, and no accumulation carries over between neurons or passes.
- R9: With N_IN = 1, every neuron is formed from its bias and a single product, under the same rules.
- R10: While rst_n is low, busy, done and y_valid are 0. Reset assertion is asynchronous and its release is synchronised internally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| start | input | 1 | Begin a layer pass |
| busy | output | 1 | Pass in progress, no new start taken |
| done | output | 1 | One-cycle pulse after the last neuron |
| w_addr | output | idx_w(N_IN·N_OUT) | Weight memory read address |
| w_data | input | DW | Weight read data, one cycle after address |
| b_addr | output | idx_w(N_OUT) | Bias memory read address |
| b_data | input | DW | Bias read data, one cycle after address |
| x_addr | output | idx_w(N_IN) | Input activation buffer read address |
| x_data | input | DW | Activation read data, one cycle after address |
| y_valid | output | 1 | Output write strobe |
| y_idx | output | idx_w(N_OUT) | Neuron index of the write |
| y_data | output | DW | ReLU-saturated neuron result |

## Verification
The main instance uses N_IN = 5, N_OUT = 4, DW = 16, ACC_W = 40 and FRAC = 8. A 20-cycle pass is long enough to show the wrap of the inner counter, neuron ordering, a start that lands mid-pass and a restart in the last issue cycle. A full-scale operand set pushes that instance into saturation. A second instance with N_IN = 1 and N_OUT = 3 makes every issue cycle both first and last of its neuron. It therefore covers bias preload and output in the same cycle, and back-to-back neuron completions.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  // index width that stays at least one bit wide
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fcl_rst_sync.sv
module fcl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fcl_seq.sv
module fcl_seq #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      start,
  output logic                                      busy,
  output logic                                      iss_vld,
  output logic                                      iss_first,
  output logic                                      iss_last,
  output logic [fcl_pkg::idx_w(N_OUT)-1:0]          iss_nrn,
  output logic [fcl_pkg::idx_w(N_IN*N_OUT)-1:0]     w_addr,
  output logic [fcl_pkg::idx_w(N_IN)-1:0]           x_addr
);

  localparam int N_W  = N_IN * N_OUT;
  localparam int IW   = fcl_pkg::idx_w(N_IN);
  localparam int NW   = fcl_pkg::idx_w(N_OUT);
  localparam int WA_W = fcl_pkg::idx_w(N_W);

  logic            issuing_q, issuing_d;
  logic [IW-1:0]   in_q, in_d;
  logic [NW-1:0]   nrn_q, nrn_d;
  logic [WA_W-1:0] wptr_q, wptr_d;
  logic            last_in, last_all, accept, en;

  always_comb begin
    last_in   = (in_q == IW'(N_IN - 1));
    last_all  = issuing_q && last_in && (nrn_q == NW'(N_OUT - 1));
    accept    = start && (!issuing_q || last_all);
    en        = accept || issuing_q;
    issuing_d = issuing_q;
    in_d      = in_q;
    nrn_d     = nrn_q;
    wptr_d    = wptr_q;
    if (accept) begin
      issuing_d = 1'b1;
      in_d      = '0;
      nrn_d     = '0;
      wptr_d    = '0;
    end else if (issuing_q) begin
      if (last_all) begin
        issuing_d = 1'b0;
      end else begin
        wptr_d = wptr_q + WA_W'(1);
        if (last_in) begin
          in_d  = '0;
          nrn_d = nrn_q + NW'(1);
        end else begin
          in_d  = in_q + IW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing_q <= 1'b0;
      in_q      <= '0;
      nrn_q     <= '0;
      wptr_q    <= '0;
    end else if (en) begin
      issuing_q <= issuing_d;
      in_q      <= in_d;
      nrn_q     <= nrn_d;
      wptr_q    <= wptr_d;
    end
  end

  assign busy      = issuing_q && !last_all;
  assign iss_vld   = issuing_q;
  assign iss_first = (in_q == '0);
  assign iss_last  = last_in;
  assign iss_nrn   = nrn_q;
  assign w_addr    = wptr_q;
  assign x_addr    = in_q;

  // R4
  issue_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issuing_q && !last_all) |=> issuing_q);

  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issuing_q |-> (int'(wptr_q) < N_W));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (issuing_q && (wptr_q == $past(wptr_q) + WA_W'(1))));

  // R4
  pass_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issuing_q) |-> (wptr_q == '0 && in_q == '0 && nrn_q == '0));

endmodule

// File: rtl/fcl_mac.sv
module fcl_mac #(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int FRAC  = 8,
  parameter int NW    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_vld,
  input  logic                    iss_first,
  input  logic                    iss_last,
  input  logic [NW-1:0]           iss_nrn,
  input  logic signed [DW-1:0]    w_data,
  input  logic signed [DW-1:0]    x_data,
  input  logic signed [DW-1:0]    b_data,
  output logic                    acc_vld,
  output logic signed [ACC_W-1:0] acc,
  output logic [NW-1:0]           acc_nrn
);

  localparam int PW = 2 * DW;

  // stage 1: tags aligned with memory read data
  logic          s1_vld, s1_first, s1_last;
  logic [NW-1:0] s1_nrn;
  // stage 2: product and scaled bias
  logic                    s2_vld, s2_first, s2_last;
  logic [NW-1:0]           s2_nrn;
  logic signed [PW-1:0]    prod_q, prod_d;
  logic signed [ACC_W-1:0] bias_q, bias_d;
  // stage 3: accumulator
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic                    vld_q;
  logic [NW-1:0]           nrn_q;

  always_comb begin
    prod_d = w_data * x_data;
    bias_d = ACC_W'(b_data) <<< FRAC;
    acc_d  = (s2_first ? bias_q : acc_q) + ACC_W'(prod_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0; s1_nrn <= '0;
      s2_vld <= 1'b0; s2_first <= 1'b0; s2_last <= 1'b0; s2_nrn <= '0;
      vld_q  <= 1'b0; nrn_q <= '0;
    end else begin
      s1_vld   <= iss_vld;
      s1_first <= iss_first;
      s1_last  <= iss_last;
      s1_nrn   <= iss_nrn;
      s2_vld   <= s1_vld;
      s2_first <= s1_first;
      s2_last  <= s1_last;
      s2_nrn   <= s1_nrn;
      vld_q    <= s2_vld && s2_last;
      if (s2_vld) nrn_q <= s2_nrn;
    end
  end

  // datapath registers carry no reset; enables keep them quiet when idle
  always_ff @(posedge clk) begin
    if (s1_vld) begin
      prod_q <= prod_d;
      bias_q <= bias_d;
    end
    if (s2_vld) acc_q <= acc_d;
  end

  assign acc_vld = vld_q;
  assign acc     = acc_q;
  assign acc_nrn = nrn_q;

  // R8
  first_seeds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && s2_first && s2_last) |=> (acc_q == $past(bias_q) + ACC_W'($past(prod_q))));

  // R5
  done_from_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(s2_vld && s2_last));

endmodule

// File: rtl/fcl_act.sv
module fcl_act #(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int FRAC  = 8,
  parameter int N_OUT = 3,
  parameter int NW    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_vld,
  input  logic signed [ACC_W-1:0] acc,
  input  logic [NW-1:0]           acc_nrn,
  output logic                    y_valid,
  output logic [NW-1:0]           y_idx,
  output logic signed [DW-1:0]    y_data,
  output logic                    done
);

  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((longint'(1) <<< (DW - 1)) - 1);

  logic signed [ACC_W-1:0] shifted;
  logic signed [DW-1:0]    y_d;
  logic                    vld_q, done_q, done_d;
  logic [NW-1:0]           idx_q;
  logic signed [DW-1:0]    data_q;

  always_comb begin
    shifted = acc >>> FRAC;
    if (acc[ACC_W-1])        y_d = '0;
    else if (shifted > Y_MAX) y_d = Y_MAX[DW-1:0];
    else                      y_d = shifted[DW-1:0];
    done_d = vld_q && (idx_q == NW'(N_OUT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      vld_q  <= acc_vld;
      done_q <= done_d;
      if (acc_vld) idx_q <= acc_nrn;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_vld) data_q <= y_d;
  end

  assign y_valid = vld_q;
  assign y_idx   = idx_q;
  assign y_data  = data_q;
  assign done    = done_q;

  // R2
  relu_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc[ACC_W-1]) |=> (y_valid && y_data == '0));

  // R3
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc[ACC_W-1] && ((acc >>> FRAC) > Y_MAX)) |=> (y_data == Y_MAX[DW-1:0]));

endmodule

// File: rtl/fcl_engine.sv
module fcl_engine #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int FRAC  = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  output logic                                  busy,
  output logic                                  done,
  output logic [fcl_pkg::idx_w(N_IN*N_OUT)-1:0] w_addr,
  input  logic signed [DW-1:0]                  w_data,
  output logic [fcl_pkg::idx_w(N_OUT)-1:0]      b_addr,
  input  logic signed [DW-1:0]                  b_data,
  output logic [fcl_pkg::idx_w(N_IN)-1:0]       x_addr,
  input  logic signed [DW-1:0]                  x_data,
  output logic                                  y_valid,
  output logic [fcl_pkg::idx_w(N_OUT)-1:0]      y_idx,
  output logic signed [DW-1:0]                  y_data
);

  localparam int NW = fcl_pkg::idx_w(N_OUT);

  logic                    rst_sync_n;
  logic                    iss_vld, iss_first, iss_last;
  logic [NW-1:0]           iss_nrn;
  logic                    acc_vld;
  logic signed [ACC_W-1:0] acc;
  logic [NW-1:0]           acc_nrn;

  fcl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fcl_seq #(.N_IN(N_IN), .N_OUT(N_OUT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .busy      (busy),
    .iss_vld   (iss_vld),
    .iss_first (iss_first),
    .iss_last  (iss_last),
    .iss_nrn   (iss_nrn),
    .w_addr    (w_addr),
    .x_addr    (x_addr)
  );

  assign b_addr = iss_nrn;

  fcl_mac #(.DW(DW), .ACC_W(ACC_W), .FRAC(FRAC), .NW(NW)) u_mac (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .iss_vld   (iss_vld),
    .iss_first (iss_first),
    .iss_last  (iss_last),
    .iss_nrn   (iss_nrn),
    .w_data    (w_data),
    .x_data    (x_data),
    .b_data    (b_data),
    .acc_vld   (acc_vld),
    .acc       (acc),
    .acc_nrn   (acc_nrn)
  );

  fcl_act #(.DW(DW), .ACC_W(ACC_W), .FRAC(FRAC), .N_OUT(N_OUT), .NW(NW)) u_act (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .acc_vld (acc_vld),
    .acc     (acc),
    .acc_nrn (acc_nrn),
    .y_valid (y_valid),
    .y_idx   (y_idx),
    .y_data  (y_data),
    .done    (done)
  );

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (y_valid && y_idx == NW'(N_OUT - 1)) |=> done);

  // R5
  idx_ascend_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (y_valid && $past(y_valid) && y_idx != '0) |-> (y_idx == $past(y_idx) + NW'(1)));

  // R10
  quiet_reset_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!busy && !done && !y_valid));

endmodule

// File: tb/fcl_engine_tb.sv
module fcl_engine_tb;

  localparam int N_IN  = 5;
  localparam int N_OUT = 4;
  localparam int DW    = 16;
  localparam int ACC_W = 40;
  localparam int FRAC  = 8;
  localparam int T     = N_IN * N_OUT;
  localparam int N_OUT1 = 3;
  localparam int T1     = N_OUT1;
  localparam longint YMAX = (longint'(1) <<< (DW - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // main instance
  logic start = 1'b0;
  logic busy, done, y_valid;
  logic [4:0] w_addr;
  logic [1:0] b_addr, y_idx;
  logic [2:0] x_addr;
  logic signed [DW-1:0] w_data, b_data, x_data, y_data;
  logic signed [DW-1:0] wm [0:T-1];
  logic signed [DW-1:0] bm [0:N_OUT-1];
  logic signed [DW-1:0] xm [0:N_IN-1];

  fcl_engine #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .ACC_W(ACC_W), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .w_addr(w_addr), .w_data(w_data), .b_addr(b_addr), .b_data(b_data),
    .x_addr(x_addr), .x_data(x_data), .y_valid(y_valid), .y_idx(y_idx), .y_data(y_data)
  );

  // single-input instance
  logic start1 = 1'b0;
  logic busy1, done1, y_valid1;
  logic [1:0] w_addr1, b_addr1, y_idx1;
  logic [0:0] x_addr1;
  logic signed [DW-1:0] w_data1, b_data1, x_data1, y_data1;
  logic signed [DW-1:0] w1m [0:N_OUT1-1];
  logic signed [DW-1:0] b1m [0:N_OUT1-1];
  logic signed [DW-1:0] x1m;

  fcl_engine #(.N_IN(1), .N_OUT(N_OUT1), .DW(DW), .ACC_W(ACC_W), .FRAC(FRAC)) u_dut_one (
    .clk(clk), .rst_n(rst_n), .start(start1), .busy(busy1), .done(done1),
    .w_addr(w_addr1), .w_data(w_data1), .b_addr(b_addr1), .b_data(b_data1),
    .x_addr(x_addr1), .x_data(x_data1), .y_valid(y_valid1), .y_idx(y_idx1), .y_data(y_data1)
  );

  // synchronous read memories, one cycle latency
  always @(posedge clk) begin
    w_data  <= wm[w_addr];
    b_data  <= bm[b_addr];
    x_data  <= xm[x_addr];
    w_data1 <= w1m[w_addr1];
    b_data1 <= b1m[b_addr1];
    x_data1 <= x1m;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint model(input longint s);
    longint q;
    if (s < 0) return 0;
    q = s >>> FRAC;
    return (q > YMAX) ? YMAX : q;
  endfunction

  function automatic longint exp_y(input int n);
    longint s = longint'(bm[n]) <<< FRAC;
    for (int i = 0; i < N_IN; i++) s += longint'(wm[n*N_IN+i]) * longint'(xm[i]);
    return model(s);
  endfunction

  function automatic longint exp_y1(input int n);
    return model((longint'(b1m[n]) <<< FRAC) + longint'(w1m[n]) * longint'(x1m));
  endfunction

  // drive a pass on the main instance and check every cycle after the accepting edge
  task automatic run_main(input string req, input int hold_end, input int pulse_e, input int npass);
    int win = npass * T + 6;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= win; c++) begin
      bit ev = 1'b0;
      int en = 0;
      @(negedge clk);
      for (int p = 0; p < npass; p++)
        for (int n = 0; n < N_OUT; n++)
          if (c == p*T + (n+1)*N_IN + 3) begin ev = 1'b1; en = n; end
      // R5
      chk(y_valid == ev, "R5", "y_valid", y_valid, ev);
      if (ev && y_valid) begin
        chk(int'(y_idx) == en, "R5", "y_idx", y_idx, en);
        chk(longint'(y_data) == exp_y(en), req, "y_data", y_data, exp_y(en));
      end
      // R6
      chk(done == (c == T+4 || (npass == 2 && c == 2*T+4)), "R6", "done", done, c);
      chk(busy == (c < npass*T && (c % T) != T-1), "R6", "busy", busy, c);
      if (c < npass*T) begin
        // R4
        chk(int'(w_addr) == c % T, "R4", "w_addr", w_addr, c % T);
        chk(int'(x_addr) == (c % T) % N_IN, "R4", "x_addr", x_addr, (c % T) % N_IN);
        chk(int'(b_addr) == (c % T) / N_IN, "R4", "b_addr", b_addr, (c % T) / N_IN);
      end
      start = ((c+1) <= hold_end) || ((c+1) == pulse_e);
    end
    start = 1'b0;
  endtask

  task automatic t_reset;
    // R10
    chk(!busy && !done && !y_valid, "R10", "outputs in reset", {busy, done, y_valid}, 0);
    chk(!busy1 && !done1 && !y_valid1, "R10", "single outputs in reset", {busy1, done1, y_valid1}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !y_valid, "R10", "idle after release", {busy, done, y_valid}, 0);
  endtask

  task automatic t_basic;
    for (int k = 0; k < T; k++) wm[k] = 16'(((k*53) % 97) - 30);
    for (int i = 0; i < N_IN; i++) xm[i] = 16'(64*(i+1));
    for (int n = 0; n < N_OUT; n++) bm[n] = 16'(n*40 - 30);
    run_main("R1", 0, -1, 1);
  endtask

  task automatic t_negative;
    for (int k = 0; k < T; k++) wm[k] = -16'sd300;
    for (int i = 0; i < N_IN; i++) xm[i] = 16'sd200;
    for (int n = 0; n < N_OUT; n++) bm[n] = -16'sd5;
    run_main("R2", 0, -1, 1);
  endtask

  task automatic t_saturate;
    for (int k = 0; k < T; k++) wm[k] = 16'sd32767;
    for (int i = 0; i < N_IN; i++) xm[i] = 16'sd32767;
    for (int n = 0; n < N_OUT; n++) bm[n] = 16'sd32767;
    // R3: every neuron clamps to the largest code
    for (int n = 0; n < N_OUT; n++) chk(exp_y(n) == YMAX, "R3", "model clamp", exp_y(n), YMAX);
    run_main("R3", 0, -1, 1);
  endtask

  task automatic t_busy_start;
    for (int k = 0; k < T; k++) wm[k] = 16'(100 - 9*k);
    for (int i = 0; i < N_IN; i++) xm[i] = 16'(300 - 70*i);
    for (int n = 0; n < N_OUT; n++) bm[n] = 16'(200 - 90*n);
    // R7: extra start pulse mid-pass
    run_main("R7", 0, 8, 1);
  endtask

  task automatic t_back_to_back;
    for (int k = 0; k < T; k++) wm[k] = 16'(((k*29) % 41) + 5);
    for (int i = 0; i < N_IN; i++) xm[i] = 16'(90 + 11*i);
    for (int n = 0; n < N_OUT; n++) bm[n] = 16'(n*3);
    // R8: start held until the final issue cycle of the first pass
    run_main("R8", T, -1, 2);
  endtask

  task automatic t_single_input;
    w1m[0] = 16'sd200; w1m[1] = -16'sd512; w1m[2] = 16'sd1000;
    b1m[0] = 16'sd10;  b1m[1] = 16'sd7;    b1m[2] = -16'sd3;
    x1m    = 16'sd300;
    @(negedge clk); start1 = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= T1 + 6; c++) begin
      bit ev = (c >= 4 && c < 4 + N_OUT1);
      @(negedge clk);
      start1 = 1'b0;
      // R9
      chk(y_valid1 == ev, "R9", "y_valid", y_valid1, ev);
      if (ev && y_valid1) begin
        chk(int'(y_idx1) == c - 4, "R9", "y_idx", y_idx1, c - 4);
        chk(longint'(y_data1) == exp_y1(c - 4), "R9", "y_data", y_data1, exp_y1(c - 4));
      end
      chk(done1 == (c == T1 + 4), "R9", "done", done1, c);
      chk(busy1 == (c < T1 - 1), "R9", "busy", busy1, c);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < T; k++) wm[k] = '0;
    for (int n = 0; n < N_OUT; n++) bm[n] = '0;
    for (int i = 0; i < N_IN; i++) xm[i] = '0;
    for (int n = 0; n < N_OUT1; n++) begin w1m[n] = '0; b1m[n] = '0; end
    x1m = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_negative();
    t_saturate();
    t_busy_start();
    t_back_to_back();
    t_single_input();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule